// File: doc/BRIEF.md
# Toggle-Handshake Global Error Reporter

This block holds a set of global error flags that are raised by hardware and acknowledged by software, both by toggling. It keeps two registers of equal width: a status word and an acknowledge word. A bit is outstanding whenever the two words disagree on it. Internal units report new errors by presenting a bit mask. Software acknowledges errors by writing a whole new acknowledge word, normally one that flips the outstanding bits.

A bit that is already outstanding cannot be raised a second time. Only newly raised bits flip the status word. When at least one bit is newly raised and the interrupt enable is high, the block issues a single-cycle interrupt pulse. The registered per-bit pending vector lets neighbouring units stall on outstanding errors. A dedicated resume pulse tells a stalled command consumer that its queue error has been acknowledged.

Top module: `gerr_toggle_top`

## Requirements
- R1: After reset, status_o, ack_o and pending_o are all zero and irq_o and resume_o are low.
- R2: pending_o equals status_o XOR ack_o. It is registered and reflects an update from the clock edge that applies it.
- R3: On a request, only those mask bits that are not pending at that edge flip in status_o; every other status bit keeps its value.
- R4: A request whose mask holds only already-pending bits, or zero, leaves status_o unchanged and produces no irq_o pulse.
- R5: irq_o is high for exactly the one cycle after an edge at which at least one bit was newly raised, and only if irq_en_i was high at that edge.
- R6: An acknowledge write with ack_we_i high makes ack_o equal to ack_wdata_i at the next edge. Flipping bits that were not pending is accepted with no error indication, and those bits then read as pending.
- R7: resume_o pulses for one cycle after an acknowledge write that flips bit CMDQ_BIT (default bit 0) while that bit is pending. Writes that leave that bit unchanged, or flip it while it is not pending, give no pulse.
- R8: When a request and an acknowledge write meet at the same edge, the new-bit filter uses the pending set from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_req_i | input | WIDTH | Error request mask from internal sources |
| irq_en_i | input | 1 | Global error interrupt enable |
| ack_we_i | input | 1 | Write strobe for the acknowledge word |
| ack_wdata_i | input | WIDTH | New acknowledge word |
| status_o | output | WIDTH | Status word, readable |
| ack_o | output | WIDTH | Acknowledge word, readable |
| pending_o | output | WIDTH | Outstanding error bits |
| irq_o | output | 1 | One-cycle error interrupt pulse |
| resume_o | output | 1 | One-cycle pulse when the command-queue error is acknowledged |

## Verification
The assertions assume that err_req_i, irq_en_i, ack_we_i and ack_wdata_i are driven to known values on every clock edge and are held at zero while reset is asserted. This means the first post-reset comparison with past values sees a quiet cycle. The bench drives every input only on falling edges, starting from zero during reset. It then runs request and write patterns that include re-raising pending bits, disabled interrupts, writes that flip non-pending bits, and requests that coincide with writes.

// File: rtl/gerr_pkg.sv
package gerr_pkg;
  parameter int unsigned GERR_WIDTH_DEF = 8;
  parameter int unsigned GERR_CMDQ_BIT_DEF = 0;
endpackage

// File: rtl/gerr_status.sv
module gerr_status #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] req_i,
  input  logic [WIDTH-1:0] pend_i,
  output logic [WIDTH-1:0] status_o,
  output logic [WIDTH-1:0] status_d_o,
  output logic             fresh_o
);
  logic [WIDTH-1:0] status_q;
  logic [WIDTH-1:0] fresh_bits;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign fresh_bits[i] = req_i[i] & ~pend_i[i];
    assign status_d_o[i] = status_q[i] ^ fresh_bits[i];
  end

  assign fresh_o = |fresh_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d_o;
  end

  assign status_o = status_q;

  p_pending_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((status_q ^ $past(status_q)) & $past(pend_i)) == '0));

  p_only_requested_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((status_q ^ $past(status_q)) & ~$past(req_i)) == '0));
endmodule

// File: rtl/gerr_ack.sv
module gerr_ack #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned CMDQ_BIT = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pend_cmdq_i,
  output logic [WIDTH-1:0] ack_o,
  output logic [WIDTH-1:0] ack_d_o,
  output logic             resume_o
);
  logic [WIDTH-1:0] ack_q;
  logic             resume_q;
  logic             cmdq_flip;

  assign ack_d_o   = we_i ? wdata_i : ack_q;
  assign cmdq_flip = we_i & (ack_q[CMDQ_BIT] ^ wdata_i[CMDQ_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q    <= '0;
      resume_q <= 1'b0;
    end else begin
      ack_q    <= ack_d_o;
      resume_q <= cmdq_flip & pend_cmdq_i;
    end
  end

  assign ack_o    = ack_q;
  assign resume_o = resume_q;

  p_ack_replace_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ack_q == $past(wdata_i)));

  p_ack_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ack_q));

  p_resume_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_q |-> ($past(we_i) && $past(pend_cmdq_i)));
endmodule

// File: rtl/gerr_toggle_top.sv
module gerr_toggle_top
  import gerr_pkg::*;
#(
  parameter int unsigned WIDTH    = GERR_WIDTH_DEF,
  parameter int unsigned CMDQ_BIT = GERR_CMDQ_BIT_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] err_req_i,
  input  logic             irq_en_i,
  input  logic             ack_we_i,
  input  logic [WIDTH-1:0] ack_wdata_i,
  output logic [WIDTH-1:0] status_o,
  output logic [WIDTH-1:0] ack_o,
  output logic [WIDTH-1:0] pending_o,
  output logic             irq_o,
  output logic             resume_o
);
  logic [WIDTH-1:0] pending_q;
  logic [WIDTH-1:0] status_d;
  logic [WIDTH-1:0] ack_d;
  logic             fresh;
  logic             irq_q;

  gerr_status #(.WIDTH(WIDTH)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (err_req_i),
    .pend_i     (pending_q),
    .status_o   (status_o),
    .status_d_o (status_d),
    .fresh_o    (fresh)
  );

  gerr_ack #(.WIDTH(WIDTH), .CMDQ_BIT(CMDQ_BIT)) u_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ack_we_i),
    .wdata_i     (ack_wdata_i),
    .pend_cmdq_i (pending_q[CMDQ_BIT]),
    .ack_o       (ack_o),
    .ack_d_o     (ack_d),
    .resume_o    (resume_o)
  );

  // pending held in its own register so the filter sees pre-write state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      pending_q <= status_d ^ ack_d;
      irq_q     <= fresh & irq_en_i;
    end
  end

  assign pending_o = pending_q;
  assign irq_o     = irq_q;

  p_pending_xor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q == (status_o ^ ack_o));

  p_irq_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ($past(irq_en_i) && (status_o != $past(status_o))));

  p_no_new_no_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_req_i & ~pending_q) == '0) |=> (!irq_q && $stable(status_o)));
endmodule

// File: tb/gerr_toggle_top_bench.sv
module gerr_toggle_top_bench;
  localparam int unsigned W  = 8;
  localparam int unsigned CB = 0;

  typedef struct {
    logic [W-1:0] status;
    logic [W-1:0] ack;
    logic [W-1:0] pend;
    logic         irq;
    logic         resume;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] err_req = '0;
  logic         irq_en = 1'b0;
  logic         ack_we = 1'b0;
  logic [W-1:0] ack_wdata = '0;
  logic [W-1:0] status, ack, pending;
  logic         irq, resume;

  int n_chk = 0;
  int n_fail = 0;
  exp_t sb[$];
  logic [W-1:0] m_status = '0;
  logic [W-1:0] m_ack = '0;
  bit done = 0;

  always #4 clk = ~clk;

  gerr_toggle_top #(.WIDTH(W), .CMDQ_BIT(CB)) u_gerr_toggle_top (
    .clk_i(clk), .rst_ni(rst_n), .err_req_i(err_req), .irq_en_i(irq_en),
    .ack_we_i(ack_we), .ack_wdata_i(ack_wdata), .status_o(status),
    .ack_o(ack), .pending_o(pending), .irq_o(irq), .resume_o(resume));

  task automatic step(input logic [W-1:0] req, input logic en, input logic we,
                      input logic [W-1:0] wd, input string tag);
    exp_t e;
    logic [W-1:0] pold, nb;
    @(negedge clk);
    err_req = req; irq_en = en; ack_we = we; ack_wdata = wd;
    pold = m_status ^ m_ack;
    nb = req & ~pold;
    e.resume = we && (((m_ack ^ wd) & pold) >> CB) % 2 == 1;
    m_status = m_status ^ nb;
    if (we) m_ack = wd;
    e.status = m_status; e.ack = m_ack; e.pend = m_status ^ m_ack;
    e.irq = en && (nb != '0);
    e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (status !== e.status || ack !== e.ack || pending !== e.pend ||
          irq !== e.irq || resume !== e.resume) begin
        n_fail++;
        $display("FAIL %s: got st=%h ack=%h pend=%h irq=%b res=%b exp st=%h ack=%h pend=%h irq=%b res=%b",
                 e.tag, status, ack, pending, irq, resume,
                 e.status, e.ack, e.pend, e.irq, e.resume);
      end
    end
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hung exp finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (status !== '0 || ack !== '0 || pending !== '0 || irq !== 1'b0 || resume !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got st=%h ack=%h pend=%h irq=%b res=%b exp all zero",
               status, ack, pending, irq, resume);
    end
    rst_n = 1'b1;
    step('0, 1, 0, '0, "R1 idle after reset");
    step(8'h05, 1, 0, '0, "R3 R5 raise 05 enabled");
    step('0, 1, 0, '0, "R5 pulse ends");
    step(8'h07, 1, 0, '0, "R3 only bit1 new");
    step(8'h05, 1, 0, '0, "R4 re-raise pending");
    step('0, 1, 0, '0, "R4 zero mask");
    step(8'h08, 0, 0, '0, "R5 raise with enable low");
    step(8'h01, 1, 1, 8'h01, "R7 R6 ack cmdq bit");
    step('0, 1, 1, 8'h03, "R7 ack non-cmdq bit no resume");
    step('0, 1, 1, 8'h43, "R6 flip non-pending bit6");
    step('0, 1, 1, 8'h42, "R7 flip cmdq while not pending");
    step(8'h04, 1, 1, 8'h46, "R8 request with same-edge ack");
    step(8'h04, 1, 0, '0, "R8 raise after ack");
    step(8'hFF, 1, 0, '0, "R3 full mask");
    step(8'hFF, 1, 1, 8'h00, "R8 full mask with clearing write");
    step('0, 1, 0, '0, "R2 quiet");
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule